// File: doc/BRIEF.md
# Strap-Configured Master Bit and Frame Clock Generator

This block produces the serial bit clock and the frame (left/right) clock of a master-mode audio converter from its master clock. The two clock pins serve a second purpose: right after reset they are left undriven, and the levels that external pull resistors place on them are read as configuration straps. The level on the frame-clock pin picks the speed family. The level on the bit-clock pin picks the master-clock-to-frame ratio family. Once the straps are captured, the block enables its pin drivers and runs both clocks until the next reset.

The bit clock always runs at 64 bit periods per frame, and both clocks have a 50% duty cycle. Frame clock transitions happen only at bit clock falling edges. In double-speed operation the frame takes half as many master clocks, so the bit clock divisor becomes 2 or 3. The divide-by-3 case still gives a 50% duty because it also uses the falling master clock edge. A one-cycle strobe marks each bit clock falling edge for the serial data path. A divide-by-two enable tells the downstream logic that double-speed was selected.

Top module: `mclk_strap_clkgen`

## Requirements
- R1: From reset until the strap capture completes, both output enables, both clock outputs, the fall strobe and the divide-by-two enable are low.
- R2: Both output enables rise in the same cycle, on the 64th rising master clock edge after reset is released (SETTLE_CYCLES), and then stay high until reset.
- R3: A frame-clock pin strap of 0 selects single speed and 1 selects double speed. After capture, the divide-by-two enable equals the speed strap (1 = double) and stays constant.
- R4: The bit clock period, in master clocks, is 4 for single speed with ratio strap 0 (256x), 6 for single speed with ratio strap 1 (384x), 2 for double speed with ratio strap 0 and 3 for double speed with ratio strap 1.
- R5: The bit clock is high for exactly half of each period. For the period of 3 this is 1.5 master clocks: it rises on a falling master clock edge and falls on a rising one.
- R6: The frame clock completes one period every 64 bit clock periods. It is low for 32 bit periods and then high for 32, starting low when the drivers enable.
- R7: The frame clock changes only in the master clock cycle in which the bit clock has just fallen.
- R8: The fall strobe is high for exactly the one master clock cycle that follows each bit clock falling edge. There are 64 strobes per frame, and there are none before the first falling edge.
- R9: Changes on the pin input values after capture have no effect on the divide-by-two enable or on the clock waveforms.
- R10: A new reset returns the pins to strap-input mode, and the straps are sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_pin_in | input | 1 | Level seen on the bit-clock pad (ratio strap) |
| lrck_pin_in | input | 1 | Level seen on the frame-clock pad (speed strap) |
| sclk_pin_out | output | 1 | Bit clock driven onto the pad |
| lrck_pin_out | output | 1 | Frame clock driven onto the pad (low = left half) |
| sclk_pin_oe | output | 1 | Bit-clock pad driver enable |
| lrck_pin_oe | output | 1 | Frame-clock pad driver enable |
| div2_en | output | 1 | Divide-by-two enable, high in double speed |
| sclk_fall_stb | output | 1 | One-cycle strobe after each bit clock falling edge |

## Verification
The bound assertions check these on every cycle: quiet outputs while the drivers are off, driver enable at exactly the end of the settling window and staying enabled, a steady divide-by-two enable, frame clock edges only at bit clock falls, and the one-to-one pairing of strobes with falling edges. Exact periods and duty, including the half-cycle high time of the divide-by-3 bit clock, need a check at each master clock half-cycle. Those checks, and the strap decoding for each of the four strap combinations with a fresh reset between them, come only from the bench's sweep. It inverts the pad inputs after capture to show they are ignored.

// File: rtl/mclk_gen_pkg.sv
// Shared types for the strap-configured clock generator.
package mclk_gen_pkg;
    // Captured strap configuration.
    typedef struct packed {
        logic dbl_speed;   // 1 = double-speed family
        logic wide_ratio;  // 1 = 384x family, 0 = 256x family
    } strap_cfg_t;
endpackage

// File: rtl/strap_capture.sv
// Strap capture: synchronises both pad levels through SYNC_STAGES flops,
// waits SETTLE_CYCLES master clocks after reset, then latches the straps
// once and raises done. Assumes pads are stable during the window.
module strap_capture
    import mclk_gen_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       speed_pad,
    input  logic       ratio_pad,
    output strap_cfg_t cfg,
    output logic       done
);
    localparam int WIN_W = $clog2(SETTLE_CYCLES + 1);

    logic [SYNC_STAGES-1:0] speed_sync;
    logic [SYNC_STAGES-1:0] ratio_sync;
    logic [WIN_W-1:0]       win_cnt;

    // Synchroniser chains for both strap pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_sync <= '0;
            ratio_sync <= '0;
        end else begin
            speed_sync <= {speed_sync[SYNC_STAGES-2:0], speed_pad};
            ratio_sync <= {ratio_sync[SYNC_STAGES-2:0], ratio_pad};
        end
    end

    // Settling window count and one-time strap latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            done    <= 1'b0;
            cfg     <= '0;
        end else if (!done) begin
            if (win_cnt == WIN_W'(SETTLE_CYCLES - 1)) begin
                done           <= 1'b1;
                cfg.dbl_speed  <= speed_sync[SYNC_STAGES-1];
                cfg.wide_ratio <= ratio_sync[SYNC_STAGES-1];
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sclk_divider.sv
// Bit clock divider: divides the master clock by a run-time divisor of
// 2 or more with 50% duty. Odd divisors AND the rising-edge phase with a
// copy retimed on the falling edge, so the falling edge of the bit clock
// always lands on a rising master clock edge. Assumes div is stable while en.
module sclk_divider #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] div,
    output logic             sclk,
    output logic             fall_stb,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] half;
    logic             last;
    logic             sclk_p;
    logic             sclk_n;

    // Next phase count and wrap detection.
    always_comb begin
        half    = div >> 1;
        last    = (cnt == div - CNT_W'(1));
        wrap    = en && last;
        cnt_nxt = !en ? '0 : (last ? '0 : cnt + CNT_W'(1));
    end

    // Phase counter, rising-edge bit clock phase and fall strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sclk_p   <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            cnt      <= cnt_nxt;
            sclk_p   <= en && (cnt_nxt >= half);
            fall_stb <= wrap;
        end
    end

    // Half-cycle retimed copy used for odd divisors.
    always_ff @(negedge clk) begin
        if (!rst_n) sclk_n <= 1'b0;
        else        sclk_n <= sclk_p;
    end

    // Pick the even or odd waveform.
    assign sclk = div[0] ? (sclk_p & sclk_n) : sclk_p;
endmodule

// File: rtl/frame_clock.sv
// Frame clock: counts bit clock periods (one advance per bit clock fall)
// and drives the frame clock low for the first half of FRAME_BITS and high
// for the second. Assumes advance pulses coincide with bit clock falls.
module frame_clock #(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic advance,
    output logic lrck
);
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic [BIT_W-1:0] bit_cnt;
    logic [BIT_W-1:0] bit_nxt;

    // Next bit position within the frame.
    always_comb begin
        if (!advance)                                bit_nxt = bit_cnt;
        else if (bit_cnt == BIT_W'(FRAME_BITS - 1))  bit_nxt = '0;
        else                                         bit_nxt = bit_cnt + 1'b1;
    end

    // Bit counter and registered frame clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bit_cnt <= '0;
            lrck    <= 1'b0;
        end else begin
            bit_cnt <= bit_nxt;
            lrck    <= (bit_nxt >= BIT_W'(FRAME_BITS / 2));
        end
    end
endmodule

// File: rtl/mclk_strap_clkgen.sv
// Top: reads the speed and ratio straps from the clock pads after reset,
// then enables the pad drivers and generates bit and frame clocks whose
// divisors follow from the captured straps.
module mclk_strap_clkgen
    import mclk_gen_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64,
    parameter int SYNC_STAGES   = 2,
    parameter int FRAME_BITS    = 64,
    parameter int RATIO_LO      = 256,
    parameter int RATIO_HI      = 384
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic sclk_pin_in,
    input  logic lrck_pin_in,
    output logic sclk_pin_out,
    output logic lrck_pin_out,
    output logic sclk_pin_oe,
    output logic lrck_pin_oe,
    output logic div2_en,
    output logic sclk_fall_stb
);
    localparam int DIV_1X_LO = RATIO_LO / FRAME_BITS;
    localparam int DIV_1X_HI = RATIO_HI / FRAME_BITS;
    localparam int DIV_2X_LO = DIV_1X_LO / 2;
    localparam int DIV_2X_HI = DIV_1X_HI / 2;
    localparam int CNT_W     = $clog2(DIV_1X_HI + 1);

    strap_cfg_t       cfg;
    logic             running;
    logic [CNT_W-1:0] div_sel;
    logic             bit_wrap;

    strap_capture #(
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_straps (
        .clk      (mclk),
        .rst_n    (rst_n),
        .speed_pad(lrck_pin_in),
        .ratio_pad(sclk_pin_in),
        .cfg      (cfg),
        .done     (running)
    );

    // Divisor chosen from the captured speed and ratio straps.
    always_comb begin
        case ({cfg.dbl_speed, cfg.wide_ratio})
            2'b00:   div_sel = CNT_W'(DIV_1X_LO);
            2'b01:   div_sel = CNT_W'(DIV_1X_HI);
            2'b10:   div_sel = CNT_W'(DIV_2X_LO);
            default: div_sel = CNT_W'(DIV_2X_HI);
        endcase
    end

    sclk_divider #(.CNT_W(CNT_W)) u_bitclk (
        .clk     (mclk),
        .rst_n   (rst_n),
        .en      (running),
        .div     (div_sel),
        .sclk    (sclk_pin_out),
        .fall_stb(sclk_fall_stb),
        .wrap    (bit_wrap)
    );

    frame_clock #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk    (mclk),
        .rst_n  (rst_n),
        .en     (running),
        .advance(bit_wrap),
        .lrck   (lrck_pin_out)
    );

    // Pad drivers and divide-by-two enable follow capture completion.
    assign sclk_pin_oe = running;
    assign lrck_pin_oe = running;
    assign div2_en     = running && cfg.dbl_speed;
endmodule

// File: rtl/mclk_strap_clkgen_chk.sv
// Checker bound to the top: port-level timing properties of the generator.
module mclk_strap_clkgen_chk #(
    parameter int SETTLE_CYCLES = 64
) (
    input logic mclk,
    input logic rst_n,
    input logic sclk_pin_out,
    input logic lrck_pin_out,
    input logic sclk_pin_oe,
    input logic div2_en,
    input logic sclk_fall_stb
);
    localparam int CYC_W = $clog2(SETTLE_CYCLES + 2);
    logic [CYC_W-1:0] cyc;

    // Saturating count of clocks since reset release.
    always_ff @(posedge mclk) begin
        if (!rst_n)                                cyc <= '0;
        else if (cyc != CYC_W'(SETTLE_CYCLES + 1)) cyc <= cyc + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
        !sclk_pin_oe |-> (!sclk_pin_out && !lrck_pin_out && !sclk_fall_stb && !div2_en)); // R1
    AST_OE_AT_WINDOW: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(sclk_pin_oe) |-> (cyc == CYC_W'(SETTLE_CYCLES))); // R2
    AST_OE_STICKY: assert property (@(posedge mclk) disable iff (!rst_n)
        sclk_pin_oe |=> sclk_pin_oe); // R2
    AST_DIV2_STEADY: assert property (@(posedge mclk) disable iff (!rst_n)
        (sclk_pin_oe && $past(sclk_pin_oe)) |-> $stable(div2_en)); // R3
    AST_LRCK_ON_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(lrck_pin_out) |-> $fell(sclk_pin_out)); // R7
    AST_STB_AFTER_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        sclk_fall_stb |-> $fell(sclk_pin_out)); // R8
    AST_FALL_HAS_STB: assert property (@(posedge mclk) disable iff (!rst_n)
        $fell(sclk_pin_out) |-> sclk_fall_stb); // R8
    AST_STB_SINGLE: assert property (@(posedge mclk) disable iff (!rst_n)
        sclk_fall_stb |=> !sclk_fall_stb); // R8
endmodule

bind mclk_strap_clkgen mclk_strap_clkgen_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .mclk         (mclk),
    .rst_n        (rst_n),
    .sclk_pin_out (sclk_pin_out),
    .lrck_pin_out (lrck_pin_out),
    .sclk_pin_oe  (sclk_pin_oe),
    .div2_en      (div2_en),
    .sclk_fall_stb(sclk_fall_stb)
);

// File: tb/mclk_strap_clkgen_tb.sv
// Sweeps all four strap combinations, with a reset before each, and checks
// every master clock half-cycle against waveforms computed arithmetically.
module mclk_strap_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 64;
    localparam int FBITS      = 64;

    logic mclk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_pad = 1'b0;
    logic lrck_pad = 1'b0;
    logic sclk_out, lrck_out, sclk_oe, lrck_oe, div2, stb;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD / 2) mclk = ~mclk;

    mclk_strap_clkgen u_dut (
        .mclk         (mclk),
        .rst_n        (rst_n),
        .sclk_pin_in  (sclk_pad),
        .lrck_pin_in  (lrck_pad),
        .sclk_pin_out (sclk_out),
        .lrck_pin_out (lrck_out),
        .sclk_pin_oe  (sclk_oe),
        .lrck_pin_oe  (lrck_oe),
        .div2_en      (div2),
        .sclk_fall_stb(stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_sclk(input int c, input int d, input bit neg_half);
        int k = c % d;
        int h = d / 2;
        if (d % 2 == 0) return k >= h;
        return neg_half ? (k >= h) : (k >= h + 1);
    endfunction

    task automatic run_cfg(input bit spd, input bit rat);
        int d = (rat ? 384 : 256) / FBITS / (spd ? 2 : 1);
        int strobes = 0;
        int highs = 0;
        // R10: a fresh reset returns the pads to strap mode
        @(negedge mclk);
        rst_n = 1'b0;
        lrck_pad = spd;
        sclk_pad = rat;
        repeat (4) @(negedge mclk);
        chk(!sclk_oe && !lrck_oe, "R10 oe off in reset", sclk_oe, 0);
        chk(!sclk_out && !lrck_out && !stb && !div2, "R1 outputs quiet in reset", sclk_out, 0);
        rst_n = 1'b1;
        for (int k = 1; k < SETTLE; k++) begin
            @(posedge mclk); #1;
            chk(!sclk_oe && !lrck_oe && !sclk_out && !lrck_out && !stb && !div2,
                "R1 quiet during window", sclk_oe, 0);
        end
        @(posedge mclk); #1;
        chk(sclk_oe && lrck_oe, "R2 drivers enable at window end", sclk_oe, 1);
        chk(div2 == spd, "R3 div2 enable matches speed strap", div2, spd);
        // R9: pads now show the opposite levels, which must be ignored
        lrck_pad = !spd;
        sclk_pad = !rat;
        for (int c = 0; c < 2 * FBITS * d + 2; c++) begin
            bit el = ((c / d) % FBITS) >= FBITS / 2;
            bit es = (c > 0) && (c % d == 0);
            if (c > 0) begin @(posedge mclk); #1; end
            chk(sclk_out == exp_sclk(c, d, 1'b0), "R4 R5 sclk rising half", sclk_out, exp_sclk(c, d, 1'b0));
            chk(lrck_out == el, "R6 R7 lrck", lrck_out, el);
            chk(stb == es, "R8 fall strobe", stb, es);
            chk(sclk_oe && lrck_oe && div2 == spd, "R9 R2 config held", div2, spd);
            if (c < FBITS * d) begin
                strobes += stb;
                highs += sclk_out;
            end
            @(negedge mclk); #1;
            chk(sclk_out == exp_sclk(c, d, 1'b1), "R5 sclk falling half", sclk_out, exp_sclk(c, d, 1'b1));
            chk(lrck_out == el, "R6 lrck falling half", lrck_out, el);
            if (c < FBITS * d) highs += sclk_out;
        end
        chk(strobes == FBITS - 1, "R8 strobes in first frame", strobes, FBITS - 1);
        chk(highs == FBITS * d, "R5 high half-cycles per frame", highs, FBITS * d);
    endtask

    initial begin
        repeat (3) @(negedge mclk);
        for (int cfg = 0; cfg < 4; cfg++) run_cfg(cfg[1], cfg[0]);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule